// File: doc/BRIEF.md
# Two-Way Inter-Processor Word Queue

This block carries 32-bit messages between two processors, called side A and side B. Each side owns an outbound queue of up to 16 words. A side pushes words into its own queue and pops words from the queue owned by its partner. Words arrive at the receiver in the order they were sent, and the two directions are independent of each other.

Each side has a 16-bit control/status word. Software writes it to set the side's enable and its two interrupt enables, to clear a sticky error flag and to flush the side's outbound queue. A read returns the enable, the interrupt enables, the error flag and four occupancy flags. The occupancy flags describe the side's outbound queue (send-empty, send-full) and the partner's queue (receive-empty, receive-full). One push or pop therefore changes the flags seen by both sides. A push to a full queue and a pop from an empty queue are both refused and set the sticky error flag of the side that tried. Each side also gets two single-cycle interrupt pulses: one when its outbound queue drains, and one when its inbound queue receives its first word.

Top module: `ipc_word_fifo`

## Requirements
- R1: Words pushed by one side are popped by the other side in push order. Each direction holds up to 16 words, and the two directions do not interact.
- R2: While bit 15 (enable) of a side's control word is 0, a push from that side leaves its queue unchanged. A pop from that side returns zero and does not remove a word. Neither action sets the error flag.
- R3: An enabled push to a queue that holds 16 words, with no pop of that queue in the same cycle, discards the word and sets bit 14 (error) of the pushing side.
- R4: An enabled pop when the partner's queue is empty returns zero and sets bit 14 (error) of the popping side.
- R5: Bit 14 stays set until the owning side writes its control word with bit 14 equal to 1. A write with bit 14 equal to 0 leaves the flag unchanged.
- R6: Bit 1 (send-full) of the sender and bit 9 (receive-full) of the receiver read 1 exactly when that queue holds 16 words.
- R7: Bit 0 (send-empty) of the sender and bit 8 (receive-empty) of the receiver read 1 exactly when that queue is empty. After reset both control words read 0x0101.
- R8: When a pop takes a queue from one word to empty and the sender's bit 2 is 1, the sender's send-empty interrupt is high for exactly the one cycle after that pop.
- R9: When a push takes a queue from empty to one word and the receiver's bit 10 is 1, the receiver's receive-ready interrupt is high for exactly the one cycle after that push.
- R10: Writing a control word with bit 3 equal to 1 empties that side's outbound queue, which sets the empty flags and clears the full flags on both sides. Bit 3 always reads 0.
- R11: A push and a pop of the same queue in one cycle keep its count unchanged, even when the queue is full, and set no error.
- R12: Only bits 15, 10 and 2 are stored by a control-word write. The remaining read bits show status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_cfg_wr | input | 1 | Side A control-word write strobe |
| a_cfg_wdata | input | 16 | Side A control-word write value |
| a_cfg_rdata | output | 16 | Side A control/status read value |
| a_push | input | 1 | Side A push strobe |
| a_push_data | input | 32 | Word pushed by side A |
| a_pop | input | 1 | Side A pop strobe |
| a_pop_data | output | 32 | Word popped by side A, valid in the cycle a_pop is high, zero if refused |
| a_irq_send_empty | output | 1 | Side A send-empty interrupt pulse |
| a_irq_recv_ready | output | 1 | Side A receive-ready interrupt pulse |
| b_cfg_wr | input | 1 | Side B control-word write strobe |
| b_cfg_wdata | input | 16 | Side B control-word write value |
| b_cfg_rdata | output | 16 | Side B control/status read value |
| b_push | input | 1 | Side B push strobe |
| b_push_data | input | 32 | Word pushed by side B |
| b_pop | input | 1 | Side B pop strobe |
| b_pop_data | output | 32 | Word popped by side B, valid in the cycle b_pop is high, zero if refused |
| b_irq_send_empty | output | 1 | Side B send-empty interrupt pulse |
| b_irq_recv_ready | output | 1 | Side B receive-ready interrupt pulse |

## Verification
The queue is exercised with a single word, a fill to 16 words followed by a full drain, a push to a full queue, a pop from an empty queue, and a push and pop of one queue in the same cycle at both a partial and a full count. The fill-and-drain run shows that ordering and both full flags are correct. The overflow and underflow attempts show that refusals are recorded and that no word is lost. The same-cycle cases show that the count is kept when both happen together. Flushing a full queue and driving a disabled side with a pending inbound word show that a flush resets the flags on both sides and that a disabled side touches nothing.

// File: rtl/ipc_fifo_pkg.sv
// Package: bit positions and widths of the inter-processor queue control word.
// Assumes: a 16-bit control word per side; positions are fixed by software.
package ipc_fifo_pkg;
    localparam int CTL_W        = 16;
    localparam int B_SEND_EMPTY = 0;
    localparam int B_SEND_FULL  = 1;
    localparam int B_SE_IRQ_EN  = 2;
    localparam int B_FLUSH      = 3;
    localparam int B_RECV_EMPTY = 8;
    localparam int B_RECV_FULL  = 9;
    localparam int B_RR_IRQ_EN  = 10;
    localparam int B_ERROR      = 14;
    localparam int B_ENABLE     = 15;
endpackage

// File: rtl/ipc_word_queue.sv
// Module: one direction's word queue (circular buffer with an occupancy count).
// Decides push/pop acceptance: a pop needs a word; a push needs room or a
// simultaneous accepted pop. Flush wins over push and pop in the same cycle.
// Assumes: DEPTH is a power of two; requests arrive already enable-qualified.
module ipc_word_queue #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push_req,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop_req,
    output logic                         push_ok,
    output logic                         pop_ok,
    output logic [$clog2(DEPTH):0]       count,
    output logic [W-1:0]                 head,
    output logic                         drained,
    output logic                         filled
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] ONE_CNT  = CW'(1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          empty, full;

    // Acceptance and edge-of-occupancy events for this cycle.
    always_comb begin
        empty   = (count == '0);
        full    = (count == FULL_CNT);
        pop_ok  = pop_req && !empty;
        push_ok = push_req && (!full || pop_ok);
        drained = pop_ok && !push_ok && (count == ONE_CNT) && !flush;
        filled  = push_ok && empty && !flush;
        head    = mem[rd_ptr];
    end

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wr_ptr] <= push_data;
    end

    // Pointer and count update, with flush returning to empty.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    a_r11_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && !empty && !flush) |=> (count == $past(count)));
    a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && !pop_req && !flush) |=> (count == FULL_CNT));
    a_r4_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop_req && !push_req && !flush) |=> (count == '0));
    a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
endmodule

// File: rtl/ipc_side_ctrl.sv
// Module: one side's stored control bits and sticky error flag.
// Stores enable and the two interrupt enables on a write; the error flag is
// set by a refused push/pop and cleared by writing 1 to its bit (set wins).
// Assumes: the flush bit is a write strobe only and is never stored.
module ipc_side_ctrl
    import ipc_fifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             err_set,
    output logic             enable,
    output logic             se_irq_en,
    output logic             rr_irq_en,
    output logic             error,
    output logic             flush
);
    // Flush strobe decoded straight from the write.
    assign flush = wr_en && wr_data[B_FLUSH];

    // Stored control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable    <= 1'b0;
            se_irq_en <= 1'b0;
            rr_irq_en <= 1'b0;
        end else if (wr_en) begin
            enable    <= wr_data[B_ENABLE];
            se_irq_en <= wr_data[B_SE_IRQ_EN];
            rr_irq_en <= wr_data[B_RR_IRQ_EN];
        end
    end

    // Sticky error flag with write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                            error <= 1'b0;
        else if (err_set)                      error <= 1'b1;
        else if (wr_en && wr_data[B_ERROR])    error <= 1'b0;
    end

    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !(wr_en && wr_data[B_ERROR])) |=> error);
    a_r5_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[B_ERROR] && !err_set) |=> !error);
endmodule

// File: rtl/ipc_word_fifo.sv
// Module: two-way inter-processor word queue, top level.
// Queue s is the outbound queue of side s and is popped by side 1-s. Status
// flags are read from both queues' counts so one event updates both sides.
// Interrupts are registered one-cycle pulses. Assumes a common clock.
module ipc_word_fifo
    import ipc_fifo_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_cfg_wr,
    input  logic [CTL_W-1:0] a_cfg_wdata,
    output logic [CTL_W-1:0] a_cfg_rdata,
    input  logic             a_push,
    input  logic [W-1:0]     a_push_data,
    input  logic             a_pop,
    output logic [W-1:0]     a_pop_data,
    output logic             a_irq_send_empty,
    output logic             a_irq_recv_ready,
    input  logic             b_cfg_wr,
    input  logic [CTL_W-1:0] b_cfg_wdata,
    output logic [CTL_W-1:0] b_cfg_rdata,
    input  logic             b_push,
    input  logic [W-1:0]     b_push_data,
    input  logic             b_pop,
    output logic [W-1:0]     b_pop_data,
    output logic             b_irq_send_empty,
    output logic             b_irq_recv_ready
);
    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic             cfg_wr   [2];
    logic [CTL_W-1:0] cfg_wdata[2];
    logic [CTL_W-1:0] cfg_rdata[2];
    logic             push     [2];
    logic [W-1:0]     push_data[2];
    logic             pop      [2];
    logic [W-1:0]     pop_data [2];
    logic             irq_se   [2];
    logic             irq_rr   [2];

    logic             enable   [2];
    logic             se_en    [2];
    logic             rr_en    [2];
    logic             error    [2];
    logic             flush_w  [2];
    logic             err_set  [2];

    logic             q_push_req[2];
    logic             q_pop_req [2];
    logic             q_push_ok [2];
    logic             q_pop_ok  [2];
    logic [CW-1:0]    q_count   [2];
    logic [W-1:0]     q_head    [2];
    logic             q_drained [2];
    logic             q_filled  [2];

    // Port-to-array mapping so both sides share one generate body.
    assign cfg_wr[0]    = a_cfg_wr;     assign cfg_wr[1]    = b_cfg_wr;
    assign cfg_wdata[0] = a_cfg_wdata;  assign cfg_wdata[1] = b_cfg_wdata;
    assign push[0]      = a_push;       assign push[1]      = b_push;
    assign push_data[0] = a_push_data;  assign push_data[1] = b_push_data;
    assign pop[0]       = a_pop;        assign pop[1]       = b_pop;
    assign a_cfg_rdata      = cfg_rdata[0];
    assign b_cfg_rdata      = cfg_rdata[1];
    assign a_pop_data       = pop_data[0];
    assign b_pop_data       = pop_data[1];
    assign a_irq_send_empty = irq_se[0];
    assign b_irq_send_empty = irq_se[1];
    assign a_irq_recv_ready = irq_rr[0];
    assign b_irq_recv_ready = irq_rr[1];

    for (genvar s = 0; s < 2; s++) begin : g_side
        localparam int P = 1 - s;

        ipc_side_ctrl u_ctrl (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (cfg_wr[s]),
            .wr_data   (cfg_wdata[s]),
            .err_set   (err_set[s]),
            .enable    (enable[s]),
            .se_irq_en (se_en[s]),
            .rr_irq_en (rr_en[s]),
            .error     (error[s]),
            .flush     (flush_w[s])
        );

        // Requests into this side's outbound queue, gated by each side's enable.
        assign q_push_req[s] = push[s] && enable[s];
        assign q_pop_req[s]  = pop[P] && enable[P];

        ipc_word_queue #(.W(W), .DEPTH(DEPTH)) u_queue (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush_w[s]),
            .push_req  (q_push_req[s]),
            .push_data (push_data[s]),
            .pop_req   (q_pop_req[s]),
            .push_ok   (q_push_ok[s]),
            .pop_ok    (q_pop_ok[s]),
            .count     (q_count[s]),
            .head      (q_head[s]),
            .drained   (q_drained[s]),
            .filled    (q_filled[s])
        );

        // Refused push to own queue or refused pop from partner queue.
        assign err_set[s] = (q_push_req[s] && !q_push_ok[s])
                          || (q_pop_req[P] && !q_pop_ok[P]);

        // Popped word: partner's head when the pop is accepted, else zero.
        assign pop_data[s] = q_pop_ok[P] ? q_head[P] : '0;

        // Control/status read value assembled from both queues.
        always_comb begin
            cfg_rdata[s]               = '0;
            cfg_rdata[s][B_ENABLE]     = enable[s];
            cfg_rdata[s][B_ERROR]      = error[s];
            cfg_rdata[s][B_RR_IRQ_EN]  = rr_en[s];
            cfg_rdata[s][B_SE_IRQ_EN]  = se_en[s];
            cfg_rdata[s][B_SEND_EMPTY] = (q_count[s] == '0);
            cfg_rdata[s][B_SEND_FULL]  = (q_count[s] == FULL_CNT);
            cfg_rdata[s][B_RECV_EMPTY] = (q_count[P] == '0);
            cfg_rdata[s][B_RECV_FULL]  = (q_count[P] == FULL_CNT);
        end

        // One-cycle interrupt pulses from queue occupancy edges.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irq_se[s] <= 1'b0;
                irq_rr[s] <= 1'b0;
            end else begin
                irq_se[s] <= q_drained[s] && se_en[s];
                irq_rr[s] <= q_filled[P] && rr_en[s];
            end
        end

        a_r8_se_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            irq_se[s] |=> !irq_se[s]);
        a_r8_se_empty: assert property (@(posedge clk) disable iff (!rst_n)
            irq_se[s] |-> (cfg_rdata[s][B_SEND_EMPTY] || $past(flush_w[s]) == 1'b0));
        a_r9_rr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            irq_rr[s] |=> !irq_rr[s]);
        a_r2_off_push: assert property (@(posedge clk) disable iff (!rst_n)
            (!enable[s] && push[s] && !q_pop_req[s] && !flush_w[s])
                |=> (q_count[s] == $past(q_count[s])));
        a_r2_off_pop: assert property (@(posedge clk) disable iff (!rst_n)
            (!enable[s] && pop[s]) |-> (pop_data[s] == '0));
    end
endmodule

// File: tb/ipc_word_fifo_tb_top.sv
// Scoreboard bench: push tasks record expected words per direction; pop
// monitor compares popped words against them. Status words checked by value.
module ipc_word_fifo_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic        a_cfg_wr, b_cfg_wr, a_push, b_push, a_pop, b_pop;
    logic [15:0] a_cfg_wdata, b_cfg_wdata, a_cfg_rdata, b_cfg_rdata;
    logic [31:0] a_push_data, b_push_data, a_pop_data, b_pop_data;
    logic        a_irq_send_empty, a_irq_recv_ready, b_irq_send_empty, b_irq_recv_ready;

    ipc_word_fifo dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_cfg_wr(a_cfg_wr), .a_cfg_wdata(a_cfg_wdata), .a_cfg_rdata(a_cfg_rdata),
        .a_push(a_push), .a_push_data(a_push_data), .a_pop(a_pop), .a_pop_data(a_pop_data),
        .a_irq_send_empty(a_irq_send_empty), .a_irq_recv_ready(a_irq_recv_ready),
        .b_cfg_wr(b_cfg_wr), .b_cfg_wdata(b_cfg_wdata), .b_cfg_rdata(b_cfg_rdata),
        .b_push(b_push), .b_push_data(b_push_data), .b_pop(b_pop), .b_pop_data(b_pop_data),
        .b_irq_send_empty(b_irq_send_empty), .b_irq_recv_ready(b_irq_recv_ready)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] sb_ab[$];
    logic [31:0] sb_ba[$];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic cfg(int s, logic [15:0] d);
        @(negedge clk);
        if (s == 0) begin a_cfg_wr = 1; a_cfg_wdata = d; end
        else        begin b_cfg_wr = 1; b_cfg_wdata = d; end
        @(negedge clk);
        a_cfg_wr = 0; b_cfg_wr = 0;
    endtask

    // Driver: push and record the word when the push is expected to be taken.
    task automatic push(int s, logic [31:0] d, bit taken);
        @(negedge clk);
        if (s == 0) begin a_push = 1; a_push_data = d; if (taken) sb_ab.push_back(d); end
        else        begin b_push = 1; b_push_data = d; if (taken) sb_ba.push_back(d); end
        @(negedge clk);
        a_push = 0; b_push = 0;
    endtask

    // Monitor: pop on side s; compare with scoreboard front (or zero if empty).
    task automatic pop_sb(int s, string tag);
        logic [31:0] got, exp;
        @(negedge clk);
        if (s == 0) a_pop = 1; else b_pop = 1;
        #1;
        got = (s == 0) ? a_pop_data : b_pop_data;
        if (s == 0) exp = (sb_ba.size() > 0) ? sb_ba.pop_front() : 32'h0;
        else        exp = (sb_ab.size() > 0) ? sb_ab.pop_front() : 32'h0;
        check(tag, got, exp);
        @(negedge clk);
        a_pop = 0; b_pop = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        rst_n = 0;
        a_cfg_wr = 0; b_cfg_wr = 0; a_push = 0; b_push = 0; a_pop = 0; b_pop = 0;
        a_cfg_wdata = 0; b_cfg_wdata = 0; a_push_data = 0; b_push_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R7 reset a", {16'h0, a_cfg_rdata}, 32'h0101);
        check("R7 reset b", {16'h0, b_cfg_rdata}, 32'h0101);
        check("R8 reset irq", {28'h0, a_irq_send_empty, a_irq_recv_ready,
                               b_irq_send_empty, b_irq_recv_ready}, 32'h0);

        cfg(0, 16'h8404); cfg(1, 16'h8404);
        check("R12 stored bits a", {16'h0, a_cfg_rdata}, 32'h8505);
        check("R12 stored bits b", {16'h0, b_cfg_rdata}, 32'h8505);

        push(0, 32'hA000_0000, 1);
        check("R9 recv pulse", {31'h0, b_irq_recv_ready}, 32'h1);
        check("R7 a send-empty cleared", {16'h0, a_cfg_rdata}, 32'h8504);
        check("R7 b recv-empty cleared", {16'h0, b_cfg_rdata}, 32'h8405);
        @(negedge clk);
        check("R9 pulse one cycle", {31'h0, b_irq_recv_ready}, 32'h0);

        for (int i = 1; i < 16; i++) push(0, 32'hA000_0000 + i, 1);
        check("R6 a send-full", {16'h0, a_cfg_rdata}, 32'h8506);
        check("R6 b recv-full", {16'h0, b_cfg_rdata}, 32'h8605);

        push(0, 32'hDEAD_BEEF, 0);
        check("R3 overflow error", {16'h0, a_cfg_rdata}, 32'hC506);
        cfg(0, 16'h8404);
        check("R5 write zero keeps error", {16'h0, a_cfg_rdata}, 32'hC506);
        cfg(0, 16'hC404);
        check("R5 write one clears", {16'h0, a_cfg_rdata}, 32'h8506);

        pop_sb(1, "R1 order first");
        check("R6 full cleared a", {16'h0, a_cfg_rdata}, 32'h8504);
        check("R6 full cleared b", {16'h0, b_cfg_rdata}, 32'h8405);
        for (int i = 1; i < 16; i++) pop_sb(1, "R1 order");
        check("R8 send-empty pulse", {31'h0, a_irq_send_empty}, 32'h1);
        check("R7 drained a", {16'h0, a_cfg_rdata}, 32'h8505);
        check("R7 drained b", {16'h0, b_cfg_rdata}, 32'h8505);
        @(negedge clk);
        check("R8 pulse one cycle", {31'h0, a_irq_send_empty}, 32'h0);

        pop_sb(1, "R4 underflow returns zero");
        check("R4 underflow error", {16'h0, b_cfg_rdata}, 32'hC505);
        cfg(1, 16'hC404);
        check("R5 clear b", {16'h0, b_cfg_rdata}, 32'h8505);

        push(1, 32'hB000_0000, 1); push(1, 32'hB000_0001, 1);
        @(negedge clk);
        b_push = 1; b_push_data = 32'hB000_0002; a_pop = 1;
        #1;
        check("R11 both pop data", a_pop_data, sb_ba.pop_front());
        sb_ba.push_back(32'hB000_0002);
        @(negedge clk);
        b_push = 0; a_pop = 0;
        pop_sb(0, "R11 order after both");
        pop_sb(0, "R11 order after both");
        check("R11 count kept", {16'h0, b_cfg_rdata}, 32'h8505);

        for (int i = 0; i < 16; i++) push(1, 32'hC000_0000 + i, 1);
        @(negedge clk);
        b_push = 1; b_push_data = 32'hC000_00FF; a_pop = 1;
        #1;
        check("R11 full both data", a_pop_data, sb_ba.pop_front());
        @(negedge clk);
        b_push = 0; a_pop = 0;
        check("R11 full kept no error b", {16'h0, b_cfg_rdata}, 32'h8506);
        check("R11 full kept a", {16'h0, a_cfg_rdata}, 32'h8605);

        cfg(1, 16'h840C);
        sb_ba.delete();
        check("R10 flush b", {16'h0, b_cfg_rdata}, 32'h8505);
        check("R10 flush a", {16'h0, a_cfg_rdata}, 32'h8505);

        push(1, 32'h0000_1234, 1);
        cfg(0, 16'h0404);
        check("R2 disabled a", {16'h0, a_cfg_rdata}, 32'h0405);
        push(0, 32'h5555_5555, 0);
        check("R2 push ignored b", {16'h0, b_cfg_rdata}, 32'h8504);
        check("R2 push no error", {16'h0, a_cfg_rdata}, 32'h0405);
        @(negedge clk);
        a_pop = 1;
        #1;
        check("R2 disabled pop zero", a_pop_data, 32'h0);
        @(negedge clk);
        a_pop = 0;
        check("R2 pop kept word", {16'h0, b_cfg_rdata}, 32'h8504);
        cfg(0, 16'h8404);
        pop_sb(0, "R1 word kept across disable");

        finish_run();
    end
endmodule